// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog. Software programs an interval, selects what should happen on expiry and turns the timer on. From then on the count falls by one on every strobe of a half-second timebase input. The count restarts only when software writes a fixed 12-bit key, together with a trigger bit, to the restart register. Any other write, including a rewrite of the mode register, leaves the running count alone.

On expiry the block does one of two things, chosen by the action field:
- With the system-reset action, it drives a reset output for a fixed number of clock cycles. It then returns every register to zero, which leaves the watchdog disabled.
- With any other action, it sets a sticky pending flag that drives the interrupt output. It then reloads the count and keeps running.

The register port is a plain single-cycle bus. A write takes effect at the clock edge where `bus_wr` is high. Reads are combinational from the address. The bus never stalls, so there is no back-pressure.

The interval code maps nonlinearly to time. Code 0 gives half a second. Codes 1 to 6 give 1 to 6 seconds in one-second steps. Codes 7 to 11 give 8 to 16 seconds in two-second steps. Codes 12 to 15 also give 16 seconds.

Top module: `keyed_wdt`

## Requirements
- R1: After reset every register reads zero, `irq_o` is 0 and `sys_rst_o` is 0.
- R2: Offset 0x14 reads the action field in bits [1:0]. Offset 0x18 reads the enable bit in bit 0 and the interval code in bits [7:4]. Offset 0x10 always reads zero, and unused bits read zero.
- R3: A write to offset 0x10 restarts the count only when bit 0 is 1 and bits [12:1] equal 0xA57 (full value 0x14AF). Any other value written there has no effect.
- R4: The count, in half-second ticks, is as follows:
  - code 0 gives 1 tick;
  - codes 1 to 6 give 2×code ticks;
  - codes 7, 8, 9, 10 and 11 give 16, 20, 24, 28 and 32 ticks;
  - codes 12 to 15 give 32 ticks.
- R5: Writing offset 0x18 with bit 0 set while the watchdog is disabled loads the interval of the code in that same write. While bit 0 is 0, ticks do not change the count. Writing all zeros stops the watchdog.
- R6: Rewriting offset 0x18 while the watchdog is enabled does not restart the count. A new code takes effect at the next valid key write, or at the next expiry.
- R7: When the action field is 01, expiry drives `sys_rst_o` high for exactly 32 cycles, starting the cycle after the expiring tick. After that, every register reads zero.
- R8: When the action field is anything other than 01, expiry sets the pending flag, which is read at bit 0 of offset 0x00 and drives `irq_o`. The count reloads and keeps running. Writing 1 to bit 0 of offset 0x00 clears the flag, but an expiry in the same cycle keeps it set.
- R9: A valid key write in the same cycle as the expiring tick wins: no expiry occurs and the count reloads.
- R10: While `sys_rst_o` is high, bus writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_half_s | input | 1 | One-cycle strobe every half second |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Pending expiry interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The interval map is exercised by enabling each of the sixteen codes in turn and counting ticks up to the interrupt. This separates the one-second steps, the two-second steps and the saturated codes. The following patterns each distinguish a different cause of a reload:
- bad keys, which must be ignored;
- a good key;
- a mode rewrite while running;
- a disable followed by a re-enable.

A key write that lands on the expiring tick, and a clear that lands on an expiry, test the priority rules. A reset-action expiry measures the pulse width, attempts a write during the pulse, and then checks that every register has been wiped.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int CODE_W    = 4;
  localparam int CNT_W     = 6;
  localparam int MAX_TICKS = 32;

  localparam logic [7:0] OFS_STAT = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h10;
  localparam logic [7:0] OFS_CFG  = 8'h14;
  localparam logic [7:0] OFS_MODE = 8'h18;

  localparam logic [1:0] ACT_SYSRST = 2'b01;

  // Interval code to count of half-second ticks
  function automatic logic [CNT_W-1:0] interval_ticks(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] c;
    c = CNT_W'(code);
    if (code == '0)
      return CNT_W'(1);
    else if (code <= CODE_W'(6))
      return c << 1;
    else if (code <= CODE_W'(11))
      return (c << 2) - CNT_W'(12);
    else
      return CNT_W'(MAX_TICKS);
  endfunction
endpackage

// File: rtl/keyed_wdt_regs.sv
module keyed_wdt_regs
  import keyed_wdt_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 32,
  parameter int          KEY_W  = 12,
  parameter logic [KEY_W-1:0] KEY = 12'hA57
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              clear_all,
  input  logic              pend,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic [CODE_W-1:0] code,
  output logic [1:0]        act,
  output logic              key_hit,
  output logic              en_rise,
  output logic [CODE_W-1:0] load_code,
  output logic              pend_clr_req
);
  localparam int CODE_LSB = 4;

  logic wr_ok, sel_stat, sel_ctrl, sel_cfg, sel_mode;

  assign wr_ok    = wr && !busy;
  assign sel_stat = (addr == ADDR_W'(OFS_STAT));
  assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign sel_cfg  = (addr == ADDR_W'(OFS_CFG));
  assign sel_mode = (addr == ADDR_W'(OFS_MODE));

  assign key_hit      = wr_ok && sel_ctrl && wdata[0] && (wdata[KEY_W:1] == KEY);
  assign en_rise      = wr_ok && sel_mode && wdata[0] && !en;
  assign load_code    = en_rise ? wdata[CODE_LSB +: CODE_W] : code;
  assign pend_clr_req = wr_ok && sel_stat && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      code <= '0;
      act  <= '0;
    end else if (clear_all) begin
      en   <= 1'b0;
      code <= '0;
      act  <= '0;
    end else if (wr_ok) begin
      if (sel_cfg) act <= wdata[1:0];
      if (sel_mode) begin
        en   <= wdata[0];
        code <= wdata[CODE_LSB +: CODE_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_stat) rdata[0] = pend;
    if (sel_cfg)  rdata[1:0] = act;
    if (sel_mode) begin
      rdata[0] = en;
      rdata[CODE_LSB +: CODE_W] = code;
    end
  end

  // R10: register state frozen during the reset pulse
  assert_frozen_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clear_all) |=> ($stable(en) && $stable(code) && $stable(act)));

  // R7: wipe at end of pulse
  assert_wiped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (!en && code == '0 && act == '0));
endmodule

// File: rtl/keyed_wdt_count.sv
module keyed_wdt_count
  import keyed_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              hold,
  input  logic              clear_all,
  input  logic              reload,
  input  logic [CODE_W-1:0] load_code,
  input  logic [CODE_W-1:0] run_code,
  output logic              fire
);
  logic [CNT_W-1:0] cnt;

  assign fire = en && tick && !hold && !reload && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clear_all)
      cnt <= '0;
    else if (hold)
      cnt <= cnt;
    else if (reload)
      cnt <= interval_ticks(load_code);
    else if (fire)
      cnt <= interval_ticks(run_code);
    else if (en && tick && cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end

  // R6: without a reload, tick or wipe the count does not move
  assert_count_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_all && !reload && !(en && tick)) |=> $stable(cnt));

  // R4: count never exceeds the longest interval
  assert_count_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_TICKS));

  // R5: an enabled watchdog always holds a live count
  assert_live_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hold) |-> (cnt != '0));
endmodule

// File: rtl/keyed_wdt_expiry.sv
module keyed_wdt_expiry
  import keyed_wdt_pkg::*;
#(
  parameter int PULSE_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [1:0] act,
  input  logic       pend_clr_req,
  output logic       busy,
  output logic       clear_all,
  output logic       pend
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic [PW-1:0] pcnt;
  logic          fire_rst, fire_irq;

  assign fire_rst  = fire && (act == ACT_SYSRST);
  assign fire_irq  = fire && (act != ACT_SYSRST);
  assign busy      = (pcnt != '0);
  assign clear_all = (pcnt == PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt <= '0;
    else if (fire_rst)
      pcnt <= PW'(PULSE_CYCLES);
    else if (busy)
      pcnt <= pcnt - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend <= 1'b0;
    else if (clear_all)
      pend <= 1'b0;
    else if (fire_irq)
      pend <= 1'b1;
    else if (pend_clr_req)
      pend <= 1'b0;
  end

  // R7: a pulse starts only from a reset-action expiry
  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fire && act == ACT_SYSRST));

  // R8: pending flag is sticky until cleared
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !pend_clr_req && !clear_all) |=> pend);

  // R8: other-action expiry raises the flag
  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act != ACT_SYSRST) |=> pend);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int KEY_W        = 12,
  parameter logic [KEY_W-1:0] KEY = 12'hA57,
  parameter int PULSE_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_half_s,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic              en, key_hit, en_rise, pend_clr_req;
  logic              busy, clear_all, pend, fire;
  logic [CODE_W-1:0] code, load_code;
  logic [1:0]        act;

  keyed_wdt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .busy(busy), .clear_all(clear_all), .pend(pend), .rdata(bus_rdata),
    .en(en), .code(code), .act(act), .key_hit(key_hit), .en_rise(en_rise),
    .load_code(load_code), .pend_clr_req(pend_clr_req)
  );

  keyed_wdt_count u_count (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick_half_s), .hold(busy),
    .clear_all(clear_all), .reload(key_hit || en_rise), .load_code(load_code),
    .run_code(code), .fire(fire)
  );

  keyed_wdt_expiry #(.PULSE_CYCLES(PULSE_CYCLES)) u_expiry (
    .clk(clk), .rst_n(rst_n), .fire(fire), .act(act),
    .pend_clr_req(pend_clr_req), .busy(busy), .clear_all(clear_all), .pend(pend)
  );

  assign irq_o     = pend;
  assign sys_rst_o = busy;

  // R9: a valid key write never coincides with an expiry
  assert_key_beats_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |-> !fire);
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick = 0;
  logic        wr = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq, srst;

  always #5 clk = ~clk;

  keyed_wdt i_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .tick_half_s(tick), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .sys_rst_o(srst)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  // Behavioural reference model
  int m_en = 0, m_code = 0, m_act = 0, m_pend = 0, m_cnt = 0, m_pulse = 0;

  function automatic int ivl(input int c);
    case (c)
      0: return 1;   1: return 2;   2: return 4;   3: return 6;
      4: return 8;   5: return 10;  6: return 12;  7: return 16;
      8: return 20;  9: return 24;  10: return 28; 11: return 32;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return 32'(m_pend);
      8'h14: return 32'(m_act);
      8'h18: return 32'((m_code << 4) | m_en);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int key, rise, fire;
    if (!rst_n) begin
      m_en = 0; m_code = 0; m_act = 0; m_pend = 0; m_cnt = 0; m_pulse = 0;
    end else if (m_pulse > 0) begin
      m_pulse--;
      if (m_pulse == 0) begin
        m_en = 0; m_code = 0; m_act = 0; m_pend = 0; m_cnt = 0;
      end
    end else begin
      key  = (wr && addr == 8'h10 && wdata[0] && wdata[12:1] == 12'hA57) ? 1 : 0;
      rise = (wr && addr == 8'h18 && wdata[0] && m_en == 0) ? 1 : 0;
      fire = (m_en != 0 && tick && m_cnt == 1 && key == 0) ? 1 : 0;
      if (rise != 0) m_cnt = ivl(int'(wdata[7:4]));
      else if (key != 0) m_cnt = ivl(m_code);
      else if (fire != 0) m_cnt = ivl(m_code);
      else if (m_en != 0 && tick && m_cnt > 0) m_cnt--;
      if (fire != 0 && m_act == 1) m_pulse = 32;
      if (fire != 0 && m_act != 1) m_pend = 1;
      else if (wr && addr == 8'h00 && wdata[0]) m_pend = 0;
      if (wr && addr == 8'h14) m_act = int'(wdata[1:0]);
      if (wr && addr == 8'h18) begin
        m_en = int'(wdata[0]);
        m_code = int'(wdata[7:4]);
      end
    end
  end

  // Per-cycle comparison, away from both clock edges
  always begin
    @(posedge clk);
    #3;
    chk("model R8 irq", 32'(irq), 32'(m_pend));
    chk("model R7 sys_rst", 32'(srst), 32'(m_pulse > 0));
    chk("model R2 rdata", rdata, m_read(addr));
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr = 1; wdata = d;
    @(negedge clk);
    wr = 0; wdata = 0;
  endtask

  task automatic one_tick();
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) one_tick();
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] e);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, e);
  endtask

  task automatic restart_with(input logic [31:0] mode_v);
    bus_write(8'h18, 32'h0);
    bus_write(8'h00, 32'h1);
    bus_write(8'h18, mode_v);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog timeout");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 irq", 32'(irq), 0);
    chk("R1 sys_rst", 32'(srst), 0);
    rd_chk("R1 stat", 8'h00, 0);
    rd_chk("R1 cfg", 8'h14, 0);
    rd_chk("R1 mode", 8'h18, 0);

    // R2
    bus_write(8'h14, 32'hFFFF_FFFE);
    rd_chk("R2 cfg", 8'h14, 32'h2);
    bus_write(8'h18, 32'hFFFF_FFA0);
    rd_chk("R2 mode", 8'h18, 32'hA0);
    bus_write(8'h10, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl", 8'h10, 0);
    bus_write(8'h14, 32'h0);

    // R4: every interval code
    for (int c = 0; c < 16; c++) begin
      int n;
      restart_with(32'((c << 4) | 1));
      n = 0;
      while (!irq && n < 40) begin
        one_tick();
        n++;
      end
      chk($sformatf("R4 code %0d ticks", c), 32'(n), 32'(ivl(c)));
    end

    // R3: bad keys ignored, good key restarts
    restart_with(32'h21);
    ticks(3);
    bus_write(8'h10, 32'h14AD);
    bus_write(8'h10, 32'h14AE);
    chk("R3 no irq yet", 32'(irq), 0);
    one_tick();
    chk("R3 bad keys ignored", 32'(irq), 1);
    bus_write(8'h00, 32'h1);
    ticks(3);
    bus_write(8'h10, 32'h14AF);
    ticks(3);
    chk("R3 good key restarted", 32'(irq), 0);
    one_tick();
    chk("R3 expiry after key", 32'(irq), 1);

    // R6: mode rewrite while running does not reload
    restart_with(32'h11);
    one_tick();
    bus_write(8'h18, 32'h31);
    one_tick();
    chk("R6 old interval kept", 32'(irq), 1);
    bus_write(8'h00, 32'h1);
    ticks(3);
    bus_write(8'h10, 32'h14AF);
    ticks(5);
    chk("R6 new interval pending", 32'(irq), 0);
    one_tick();
    chk("R6 new interval used", 32'(irq), 1);

    // R5: disable freezes, re-enable reloads, zeros stop
    restart_with(32'h21);
    ticks(2);
    bus_write(8'h18, 32'h20);
    ticks(10);
    chk("R5 frozen", 32'(irq), 0);
    rd_chk("R5 mode readback", 8'h18, 32'h20);
    bus_write(8'h18, 32'h21);
    ticks(3);
    chk("R5 reloaded", 32'(irq), 0);
    one_tick();
    chk("R5 expiry after reenable", 32'(irq), 1);
    bus_write(8'h18, 32'h0);
    bus_write(8'h00, 32'h1);
    ticks(40);
    chk("R5 stopped", 32'(irq), 0);

    // R9: key write on the expiring tick wins
    restart_with(32'h11);
    one_tick();
    @(negedge clk);
    tick = 1; wr = 1; addr = 8'h10; wdata = 32'h14AF;
    @(negedge clk);
    tick = 0; wr = 0; wdata = 0;
    chk("R9 no expiry", 32'(irq), 0);
    one_tick();
    chk("R9 reloaded", 32'(irq), 0);
    one_tick();
    chk("R9 later expiry", 32'(irq), 1);

    // R8: set beats clear, clear works, periodic re-fire
    restart_with(32'h01);
    one_tick();
    chk("R8 set", 32'(irq), 1);
    @(negedge clk);
    tick = 1; wr = 1; addr = 8'h00; wdata = 32'h1;
    @(negedge clk);
    tick = 0; wr = 0; wdata = 0;
    chk("R8 set wins over clear", 32'(irq), 1);
    rd_chk("R8 stat bit", 8'h00, 32'h1);
    bus_write(8'h00, 32'h1);
    chk("R8 cleared", 32'(irq), 0);
    one_tick();
    chk("R8 re-fire", 32'(irq), 1);

    // R7 and R10: reset pulse
    restart_with(32'h0);
    bus_write(8'h14, 32'h1);
    bus_write(8'h18, 32'h01);
    one_tick();
    chk("R7 pulse start", 32'(srst), 1);
    begin
      int n;
      n = 0;
      while (srst && n < 100) begin
        n++;
        if (n == 3) begin
          addr = 8'h14; wr = 1; wdata = 32'h3;
        end
        if (n == 4) begin
          wr = 0; wdata = 0;
          #1;
          chk("R10 write ignored", rdata, 32'h1);
        end
        @(negedge clk);
      end
      chk("R7 pulse length", 32'(n), 32);
    end
    rd_chk("R7 cfg wiped", 8'h14, 0);
    rd_chk("R7 mode wiped", 8'h18, 0);
    rd_chk("R7 stat wiped", 8'h00, 0);
    chk("R7 irq low", 32'(irq), 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule